// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration image into a downstream programmable device over a two-wire serial link. A host gives a one-cycle start pulse with the total image length in bytes. It then hands the bytes over one at a time on a valid/ready handshake. The block sequences the whole load without further help from the host.

A load proceeds in a fixed order:
- The block holds the active-low config request output low for a timed reset window. It checks that the device pulls its active-low status line low during that window.
- It releases the request, waits a settling interval, and polls until the device lets the status line go high. This poll has a timeout.
- It shifts every byte out least significant bit first. The data line changes while the serial clock is low, and the device samples on the rising clock edge.
- After the last byte it checks the done input. It then sends a fixed burst of extra clock pulses and reports success.

Any failure ends the load with a one-cycle error pulse and a cause code. A host abort during the data phase ends the load the same way. In every case the block drops back to idle with the request released and the serial clock low.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, and whenever reset is asserted mid-load, the outputs read as follows: cfg_req_n_o=1, sclk_o=0, sdata_o=0, busy_o=0, s_ready_o=0, err_code_o=0.
- R2: A start pulse in idle raises busy_o and drives cfg_req_n_o low for at least RST_CYC consecutive clock cycles.
- R3: If stat_n_i is high at the end of the reset window, the load fails with err_code_o=1 and no serial clock edges.
- R4: If stat_n_i has not gone high within TMO_CYC cycles after the settling interval, the load fails with err_code_o=2 and no serial clock edges.
- R5: Each byte produces exactly 8 rising edges of sclk_o. The value of sdata_o at the k-th rising edge is bit k of the byte (bit 0 first), and sdata_o does not change while sclk_o is high.
- R6: s_ready_o is high only while the serializer is idle during the data phase. Exactly byte_count_i bytes are accepted per load.
- R7: If done_i is low after the last byte, the load fails with err_code_o=3, and no clock edges follow the data bits.
- R8: With done_i high after the last byte, exactly TRAIL_PULSES (12) further rising edges of sclk_o occur, followed by success_o.
- R9: abort_i during the data phase stops the load at once and gives error_o with err_code_o=0. abort_i outside the data phase has no effect.
- R10: After success or error the block is idle, with cfg_req_n_o=1, sclk_o=0 and busy_o=0. err_code_o holds its value until the next start.
- R11: success_o and error_o are single-cycle pulses, never high together, and each coincides with busy_o falling.
- R12: A byte count of zero skips the data phase. The load goes straight from the status release to the done check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a load (sampled in idle) |
| byte_count_i | input | CNT_W | Number of image bytes for this load |
| abort_i | input | 1 | Host abort request |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_ready_o | output | 1 | Block can take a byte |
| cfg_req_n_o | output | 1 | Active-low config request to the device |
| stat_n_i | input | 1 | Active-low status from the device |
| done_i | input | 1 | Configuration complete from the device |
| sclk_o | output | 1 | Serial clock to the device |
| sdata_o | output | 1 | Serial data to the device |
| busy_o | output | 1 | Load in progress |
| success_o | output | 1 | One-cycle pulse on successful completion |
| error_o | output | 1 | One-cycle pulse on failure |
| err_code_o | output | 2 | Failure cause: 0 abort/none, 1 status not asserted, 2 release timeout, 3 done missing |

## Verification
Some properties hold in every cycle, and the assertions check those. success_o and error_o are exclusive pulses, and both coincide with the end of busy. The handshake stays inside a load. The serial clock is quiet while the request is low, and the data line is stable while the clock is high. Each error cause is tied to the input level that caused it.

Other behaviour only shows up when whole loads run under a device model in the bench. That covers the bit order, the exact count of data and trailing edges, the number of bytes accepted, the length of the reset window, the two timeouts and the effect of an abort.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_SETTLE,
    ST_WAIT,
    ST_FEED,
    ST_SHIFT,
    ST_CHECK,
    ST_TRAIL
  } seq_state_t;

  typedef enum logic [1:0] {
    CAUSE_NONE      = 2'd0,
    CAUSE_NO_STATUS = 2'd1,
    CAUSE_REL_TMO   = 2'd2,
    CAUSE_NO_DONE   = 2'd3
  } cause_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] value_i,
  output logic          expired_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= value_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ps_cfg_bytecnt.sv
module ps_cfg_bytecnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic             dec_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= value_i;
    end else if (dec_i && (left_q != '0)) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign zero_o = (left_q == '0);

endmodule

// File: rtl/ps_cfg_serializer.sv
module ps_cfg_serializer #(
  parameter int HALF_CYC     = 1,
  parameter int TRAIL_PULSES = 12,
  parameter bit LSB_FIRST    = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_i,
  input  logic       trail_i,
  input  logic       clear_i,
  input  logic [7:0] byte_i,
  output logic       sclk_o,
  output logic       sdata_o,
  output logic       done_o
);

  localparam int NP_MAX = (TRAIL_PULSES > 8) ? TRAIL_PULSES : 8;
  localparam int PW     = $clog2(NP_MAX + 1);
  localparam int HW     = (HALF_CYC > 1) ? $clog2(HALF_CYC + 1) : 1;

  logic [7:0]    ordered;
  logic [7:0]    sreg_q;
  logic [HW-1:0] hcnt_q;
  logic [PW-1:0] pcnt_q;
  logic          active_q;
  logic          high_q;
  logic          trail_q;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign ordered = byte_i;
    end else begin : g_msb
      for (genvar b = 0; b < 8; b++) begin : g_rev
        assign ordered[b] = byte_i[7-b];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q   <= '0;
      hcnt_q   <= '0;
      pcnt_q   <= '0;
      active_q <= 1'b0;
      high_q   <= 1'b0;
      trail_q  <= 1'b0;
      sclk_o   <= 1'b0;
      sdata_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clear_i) begin
        active_q <= 1'b0;
        high_q   <= 1'b0;
        sclk_o   <= 1'b0;
        sdata_o  <= 1'b0;
        sreg_q   <= '0;
      end else if (go_i) begin
        active_q <= 1'b1;
        high_q   <= 1'b0;
        sclk_o   <= 1'b0;
        hcnt_q   <= HW'(HALF_CYC - 1);
        trail_q  <= trail_i;
        if (trail_i) begin
          sdata_o <= 1'b0;
          sreg_q  <= '0;
          pcnt_q  <= PW'(TRAIL_PULSES - 1);
        end else begin
          sdata_o <= ordered[0];
          sreg_q  <= {1'b0, ordered[7:1]};
          pcnt_q  <= PW'(7);
        end
      end else if (active_q) begin
        if (hcnt_q != '0) begin
          hcnt_q <= hcnt_q - 1'b1;
        end else begin
          hcnt_q <= HW'(HALF_CYC - 1);
          if (!high_q) begin
            high_q <= 1'b1;
            sclk_o <= 1'b1;
          end else if (pcnt_q == '0) begin
            active_q <= 1'b0;
            high_q   <= 1'b0;
            done_o   <= 1'b1;
            if (trail_q) sclk_o <= 1'b0;
          end else begin
            pcnt_q  <= pcnt_q - 1'b1;
            high_q  <= 1'b0;
            sclk_o  <= 1'b0;
            sdata_o <= sreg_q[0];
            sreg_q  <= {1'b0, sreg_q[7:1]};
          end
        end
      end
    end
  end

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
  import ps_cfg_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int RST_CYC      = 120,
  parameter int SETTLE_CYC   = 120,
  parameter int TMO_CYC      = 5000000,
  parameter int HALF_CYC     = 1,
  parameter int TRAIL_PULSES = 12,
  parameter bit LSB_FIRST    = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic             abort_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  output logic             cfg_req_n_o,
  input  logic             stat_n_i,
  input  logic             done_i,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             busy_o,
  output logic             success_o,
  output logic             error_o,
  output logic [1:0]       err_code_o
);

  localparam int TMAX = max3(RST_CYC, SETTLE_CYC, TMO_CYC);
  localparam int TW   = $clog2(TMAX + 1);

  seq_state_t    state_q;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_exp;
  logic          cnt_load;
  logic          cnt_dec;
  logic          cnt_zero;
  logic          ser_go;
  logic          ser_trail;
  logic          ser_clear;
  logic          ser_done;
  logic          fail_now;
  cause_t        fail_cause;
  logic          take_byte;

  assign take_byte = (state_q == ST_FEED) && s_valid_i && s_ready_o && !abort_i;

  always_comb begin
    fail_now   = 1'b0;
    fail_cause = CAUSE_NONE;
    unique case (state_q)
      ST_RST: begin
        if (tmr_exp && stat_n_i) begin
          fail_now   = 1'b1;
          fail_cause = CAUSE_NO_STATUS;
        end
      end
      ST_WAIT: begin
        if (!stat_n_i && tmr_exp) begin
          fail_now   = 1'b1;
          fail_cause = CAUSE_REL_TMO;
        end
      end
      ST_FEED, ST_SHIFT: begin
        if (abort_i) begin
          fail_now   = 1'b1;
          fail_cause = CAUSE_NONE;
        end
      end
      ST_CHECK: begin
        if (!done_i) begin
          fail_now   = 1'b1;
          fail_cause = CAUSE_NO_DONE;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    tmr_load  = 1'b0;
    tmr_val   = '0;
    cnt_load  = 1'b0;
    cnt_dec   = 1'b0;
    ser_go    = 1'b0;
    ser_trail = 1'b0;
    ser_clear = fail_now;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(RST_CYC);
          cnt_load = 1'b1;
        end
      end
      ST_RST: begin
        if (tmr_exp && !stat_n_i) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(SETTLE_CYC);
        end
      end
      ST_SETTLE: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(TMO_CYC);
        end
      end
      ST_FEED: begin
        if (take_byte) begin
          ser_go  = 1'b1;
          cnt_dec = 1'b1;
        end
      end
      ST_CHECK: begin
        if (done_i) begin
          ser_go    = 1'b1;
          ser_trail = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cfg_req_n_o <= 1'b1;
      busy_o      <= 1'b0;
      s_ready_o   <= 1'b0;
      success_o   <= 1'b0;
      error_o     <= 1'b0;
      err_code_o  <= 2'd0;
    end else begin
      success_o <= 1'b0;
      error_o   <= 1'b0;
      if (fail_now) begin
        state_q     <= ST_IDLE;
        cfg_req_n_o <= 1'b1;
        busy_o      <= 1'b0;
        s_ready_o   <= 1'b0;
        error_o     <= 1'b1;
        err_code_o  <= fail_cause;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (start_i) begin
              state_q     <= ST_RST;
              cfg_req_n_o <= 1'b0;
              busy_o      <= 1'b1;
              err_code_o  <= 2'd0;
            end
          end
          ST_RST: begin
            if (tmr_exp) begin
              cfg_req_n_o <= 1'b1;
              state_q     <= ST_SETTLE;
            end
          end
          ST_SETTLE: begin
            if (tmr_exp) state_q <= ST_WAIT;
          end
          ST_WAIT: begin
            if (stat_n_i) begin
              if (cnt_zero) begin
                state_q <= ST_CHECK;
              end else begin
                state_q   <= ST_FEED;
                s_ready_o <= 1'b1;
              end
            end
          end
          ST_FEED: begin
            if (take_byte) begin
              s_ready_o <= 1'b0;
              state_q   <= ST_SHIFT;
            end
          end
          ST_SHIFT: begin
            if (ser_done) begin
              if (cnt_zero) begin
                state_q <= ST_CHECK;
              end else begin
                state_q   <= ST_FEED;
                s_ready_o <= 1'b1;
              end
            end
          end
          ST_CHECK: begin
            state_q <= ST_TRAIL;
          end
          ST_TRAIL: begin
            if (ser_done) begin
              state_q   <= ST_IDLE;
              busy_o    <= 1'b0;
              success_o <= 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  ps_cfg_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .value_i   (tmr_val),
    .expired_o (tmr_exp)
  );

  ps_cfg_bytecnt #(.CNT_W(CNT_W)) u_bytecnt (
    .clk     (clk),
    .rst     (rst),
    .load_i  (cnt_load),
    .value_i (byte_count_i),
    .dec_i   (cnt_dec),
    .zero_o  (cnt_zero)
  );

  ps_cfg_serializer #(
    .HALF_CYC     (HALF_CYC),
    .TRAIL_PULSES (TRAIL_PULSES),
    .LSB_FIRST    (LSB_FIRST)
  ) u_ser (
    .clk     (clk),
    .rst     (rst),
    .go_i    (ser_go),
    .trail_i (ser_trail),
    .clear_i (ser_clear),
    .byte_i  (s_data_i),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .done_o  (ser_done)
  );

endmodule

// File: rtl/ps_cfg_master_chk.sv
module ps_cfg_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       s_valid_i,
  input logic       s_ready_o,
  input logic       cfg_req_n_o,
  input logic       stat_n_i,
  input logic       done_i,
  input logic       sclk_o,
  input logic       sdata_o,
  input logic       busy_o,
  input logic       success_o,
  input logic       error_o,
  input logic [1:0] err_code_o
);

  assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(success_o && error_o));

  assert_success_single_R11: assert property (@(posedge clk) disable iff (rst)
    success_o |=> !success_o);

  assert_error_single_R11: assert property (@(posedge clk) disable iff (rst)
    error_o |=> !error_o);

  assert_end_clears_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (success_o || error_o) |-> !busy_o);

  assert_ready_in_load_R6: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> (busy_o && cfg_req_n_o));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (cfg_req_n_o && !sclk_o));

  assert_req_starts_load_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_req_n_o) |-> busy_o);

  assert_no_clock_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_req_n_o |-> !sclk_o);

  assert_data_stable_high_R5: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  assert_cause_status_R3: assert property (@(posedge clk) disable iff (rst)
    (error_o && err_code_o == 2'd1) |-> ($past(stat_n_i) && !$past(cfg_req_n_o)));

  assert_cause_done_R7: assert property (@(posedge clk) disable iff (rst)
    (error_o && err_code_o == 2'd3) |-> !$past(done_i));

  assert_cause_timeout_R4: assert property (@(posedge clk) disable iff (rst)
    (error_o && err_code_o == 2'd2) |-> !$past(stat_n_i));

  assert_valid_known_R6: assert property (@(posedge clk) disable iff (rst)
    (s_ready_o && s_valid_i) |=> !s_ready_o);

endmodule

bind ps_cfg_master ps_cfg_master_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .s_valid_i   (s_valid_i),
  .s_ready_o   (s_ready_o),
  .cfg_req_n_o (cfg_req_n_o),
  .stat_n_i    (stat_n_i),
  .done_i      (done_i),
  .sclk_o      (sclk_o),
  .sdata_o     (sdata_o),
  .busy_o      (busy_o),
  .success_o   (success_o),
  .error_o     (error_o),
  .err_code_o  (err_code_o)
);

// File: tb/sim_ps_cfg_master.sv
module sim_ps_cfg_master;

  localparam int CNT_W    = 16;
  localparam int RST_CYC  = 4;
  localparam int SET_CYC  = 3;
  localparam int TMO_CYC  = 40;
  localparam int HALF_CYC = 2;
  localparam int TRAIL    = 12;

  typedef struct packed {
    logic [3:0] nb;
    logic       stat_ok;
    logic       rel_ok;
    logic       done_v;
    logic [3:0] abort_at;
    logic [1:0] code;
    logic       ok;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 1'b1, 1'b1, 1'b1, 4'hF, 2'd0, 1'b1},
    '{4'd1, 1'b1, 1'b1, 1'b1, 4'hF, 2'd0, 1'b1},
    '{4'd5, 1'b1, 1'b1, 1'b1, 4'hF, 2'd0, 1'b1},
    '{4'd2, 1'b0, 1'b1, 1'b1, 4'hF, 2'd1, 1'b0},
    '{4'd2, 1'b1, 1'b0, 1'b1, 4'hF, 2'd2, 1'b0},
    '{4'd4, 1'b1, 1'b1, 1'b0, 4'hF, 2'd3, 1'b0},
    '{4'd4, 1'b1, 1'b1, 1'b1, 4'd2, 2'd0, 1'b0},
    '{4'd0, 1'b1, 1'b1, 1'b1, 4'hF, 2'd0, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] byte_count_i = '0;
  logic             abort_i = 1'b0;
  logic [7:0]       s_data_i = '0;
  logic             s_valid_i = 1'b0;
  logic             s_ready_o;
  logic             cfg_req_n_o;
  logic             stat_n_i = 1'b1;
  logic             done_i = 1'b0;
  logic             sclk_o;
  logic             sdata_o;
  logic             busy_o;
  logic             success_o;
  logic             error_o;
  logic [1:0]       err_code_o;

  int n_checks = 0;
  int n_errors = 0;

  logic m_stat_ok = 1'b1;
  logic m_rel_ok  = 1'b1;
  int   rel_cnt   = 0;

  logic       prev_sclk = 1'b0;
  logic       cap [0:255];
  int         edge_n = 0;
  int         low_n = 0;
  int         acc_n = 0;
  logic       got_ok = 1'b0;
  logic       got_err = 1'b0;

  always #10 clk = ~clk;

  ps_cfg_master #(
    .CNT_W        (CNT_W),
    .RST_CYC      (RST_CYC),
    .SETTLE_CYC   (SET_CYC),
    .TMO_CYC      (TMO_CYC),
    .HALF_CYC     (HALF_CYC),
    .TRAIL_PULSES (TRAIL),
    .LSB_FIRST    (1'b1)
  ) u0 (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .byte_count_i (byte_count_i),
    .abort_i      (abort_i),
    .s_data_i     (s_data_i),
    .s_valid_i    (s_valid_i),
    .s_ready_o    (s_ready_o),
    .cfg_req_n_o  (cfg_req_n_o),
    .stat_n_i     (stat_n_i),
    .done_i       (done_i),
    .sclk_o       (sclk_o),
    .sdata_o      (sdata_o),
    .busy_o       (busy_o),
    .success_o    (success_o),
    .error_o      (error_o),
    .err_code_o   (err_code_o)
  );

  // Device model: pulls status low during the request, releases it later.
  always @(posedge clk) begin
    if (!cfg_req_n_o) begin
      stat_n_i <= m_stat_ok ? 1'b0 : 1'b1;
      rel_cnt  <= 0;
    end else if (!stat_n_i && m_rel_ok) begin
      if (rel_cnt == 5) stat_n_i <= 1'b1;
      else rel_cnt <= rel_cnt + 1;
    end
  end

  // Output monitor, sampled between clock edges.
  always @(negedge clk) begin
    if (sclk_o && !prev_sclk && edge_n < 256) begin
      cap[edge_n] = sdata_o;
      edge_n = edge_n + 1;
    end
    prev_sclk = sclk_o;
    if (!cfg_req_n_o) low_n = low_n + 1;
    if (success_o) got_ok = 1'b1;
    if (error_o) got_err = 1'b1;
  end

  initial begin
    repeat (150000) @(negedge clk);
    n_errors = n_errors + 1;
    $display("FAIL R1 watchdog expired: actual cycles=150000 expected fewer");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_errors = n_errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int s, input int k);
    return 8'((s * 37 + k * 91 + 5) & 255);
  endfunction

  function automatic string code_tag(input logic [1:0] c);
    case (c)
      2'd1: return "R3 cause code";
      2'd2: return "R4 cause code";
      2'd3: return "R7 cause code";
      default: return "R9 cause code";
    endcase
  endfunction

  task automatic run_vec(input int s, input vec_t v);
    int w;
    int bad;
    m_stat_ok = v.stat_ok;
    m_rel_ok  = v.rel_ok;
    done_i    = v.done_v;
    @(negedge clk);
    edge_n = 0; low_n = 0; acc_n = 0; got_ok = 1'b0; got_err = 1'b0;
    start_i = 1'b1;
    byte_count_i = CNT_W'(v.nb);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
    for (int k = 0; k < int'(v.nb); k++) begin
      if (k == int'(v.abort_at)) begin
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        break;
      end
      s_data_i  = bval(s, k);
      s_valid_i = 1'b1;
      while (!s_ready_o && !(got_ok || got_err)) @(negedge clk);
      if (got_ok || got_err) begin
        s_valid_i = 1'b0;
        break;
      end
      acc_n = acc_n + 1;
      @(negedge clk);
      s_valid_i = 1'b0;
    end
    w = 0;
    while (!(got_ok || got_err) && w < 3000) begin
      @(negedge clk);
      w++;
    end
    @(negedge clk);
    check(got_ok == v.ok, "R8 success reported", int'(got_ok), int'(v.ok));
    check(got_err == !v.ok, "R11 error reported", int'(got_err), int'(!v.ok));
    check(err_code_o == v.code, code_tag(v.code), int'(err_code_o), int'(v.code));
    check(low_n >= RST_CYC, "R2 request low cycles", low_n, RST_CYC);
    if (v.ok) begin
      check(edge_n == 8 * int'(v.nb) + TRAIL,
            (v.nb == 0) ? "R12 edges with zero bytes" : "R8 data plus trailing edges",
            edge_n, 8 * int'(v.nb) + TRAIL);
    end else if (v.code == 2'd3) begin
      check(edge_n == 8 * int'(v.nb), "R7 no trailing edges", edge_n, 8 * int'(v.nb));
    end else if (v.code == 2'd0) begin
      check(edge_n < 16, "R9 clocks stop on abort", edge_n, 15);
    end else begin
      check(edge_n == 0, (v.code == 2'd1) ? "R3 no clocks" : "R4 no clocks", edge_n, 0);
    end
    if (v.ok || v.code == 2'd3) begin
      bad = 0;
      for (int k = 0; k < int'(v.nb); k++)
        for (int b = 0; b < 8; b++)
          if (cap[8 * k + b] != bval(s, k)[b]) bad++;
      check(bad == 0, "R5 bits LSB first", bad, 0);
    end
    if (v.ok || v.code == 2'd3) check(acc_n == int'(v.nb), "R6 bytes accepted", acc_n, int'(v.nb));
    else if (v.code == 2'd0) check(acc_n == 2, "R9 bytes before abort", acc_n, 2);
    else check(acc_n == 0, "R6 no bytes on early fail", acc_n, 0);
    check(!busy_o && cfg_req_n_o && !sclk_o && !s_ready_o, "R10 idle after end",
          int'({busy_o, cfg_req_n_o, sclk_o, s_ready_o}), 4);
  endtask

  initial begin
    logic [1:0] held;
    repeat (3) @(negedge clk);
    check(cfg_req_n_o == 1'b1, "R1 request released", int'(cfg_req_n_o), 1);
    check(!sclk_o && !sdata_o, "R1 serial lines low", int'({sclk_o, sdata_o}), 0);
    check(!busy_o && !s_ready_o, "R1 busy and ready low", int'({busy_o, s_ready_o}), 0);
    check(err_code_o == 2'd0, "R1 cause cleared", int'(err_code_o), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

    // Abort in idle: no effect, code held from the previous load (R9, R10).
    run_vec(20, VECS[5]);
    held = err_code_o;
    got_err = 1'b0;
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!got_err && !busy_o, "R9 idle abort ignored", int'(got_err), 0);
    check(err_code_o == held, "R10 cause held", int'(err_code_o), int'(held));

    // Reset in the middle of the data phase (R1).
    m_stat_ok = 1'b1; m_rel_ok = 1'b1; done_i = 1'b1;
    start_i = 1'b1; byte_count_i = CNT_W'(3);
    @(negedge clk);
    start_i = 1'b0;
    s_data_i = 8'hA5; s_valid_i = 1'b1;
    for (int w = 0; w < 200 && !s_ready_o; w++) @(negedge clk);
    @(negedge clk);
    s_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(cfg_req_n_o && !busy_o && !s_ready_o, "R1 mid-load reset state",
          int'({cfg_req_n_o, busy_o, s_ready_o}), 4);
    check(!sclk_o && !sdata_o && err_code_o == 2'd0, "R1 mid-load reset serial",
          int'({sclk_o, sdata_o, err_code_o}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run_vec(30, VECS[0]);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule